// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the digital front end of a small serial EEPROM with a 4096-byte array. It runs on a system clock that is much faster than the serial clock and detects the serial clock edges itself. A host drives chip select, the serial clock and the serial data input. It sends a one-byte opcode, then an optional 16-bit address and data bytes. The block answers on its serial data output, which has a separate output-enable. A pause input stops the transfer without losing its place. A write-protect input freezes the protection setting.

Writes are staged in a one-page buffer while chip select is low. After chip select rises on a valid command, a counted busy window models the self-timed write cycle, and the buffered page is committed to the array during it. A write-enable latch gates every write. A two-bit lock field makes none, the top quarter, the top half or all of the array read-only. Reads stream continuously and wrap around the array.

Top module: `sbe_eeprom`

## Requirements
- R1: While chip select is low, serial input bits are taken MSB first on rising serial-clock edges. Output bits are presented MSB first, and each is valid before the rising edge that follows. This holds whether the clock idles low or high before chip select falls (mode 0 or mode 3).
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it.
- R3: Opcode 0x05 returns the status byte, repeated for as long as chip select stays low. Status bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the lock code and bits 7:4 read zero. The status byte is 0x00 after reset.
- R4: Opcode 0x03, followed by a 16-bit address whose top 4 bits are ignored, streams bytes from consecutive addresses. The address wraps from 0xFFF to 0x000.
- R5: Opcode 0x02, followed by an address and 1 to 32 data bytes, writes those bytes within the 32-byte page of the address. Data past the page end wraps to the start of the same page. Bytes of the page that are not sent keep their old value.
- R6: A write is accepted only if the latch is set, at least one whole data byte was sent, and chip select rises on a byte boundary. Otherwise the array and the status byte are unchanged and no busy window starts.
- R7: An accepted write sets busy for WR_CYCLES system clocks (never fewer than the page size). After that, busy and the write-enable latch both read 0.
- R8: While busy, every opcode except 0x05 is ignored. Opcode 0x04 does not clear the latch, and a read returns 0x00.
- R9: Opcode 0x01 with one data byte loads data bits 3:2 into the lock code. It needs the latch set and starts a busy window.
- R10: Lock code 01 protects addresses 0xC00 to 0xFFF, 10 protects 0x800 to 0xFFF, and 11 protects everything. A write to a protected page is dropped, with no busy window, and the latch stays set.
- R11: With the write-protect input low when chip select rises, a status write is dropped. The lock code is unchanged and no busy window starts.
- R12: While the pause input is low, serial clock edges are ignored and the output-enable is low. The command resumes where it stopped once the pause input is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from host |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output-enable for spi_so |
| hold_n | input | 1 | Pause transfer when low |
| wp_n | input | 1 | Freeze status writes when low |

## Verification
Several rules hold on every cycle and are checked as properties:
- no array write ever lands in a page covered by the current lock code;
- the lock code never changes unless the write-protect input was high;
- a busy window only starts with the latch set, and the latch cannot be set while busy;
- the latch is clear when busy ends;
- no byte completes while paused.

Only the directed scenarios can show the rest, because each depends on a whole serial transaction:
- data round trips, including page wrap, array wrap and ignored upper address bits;
- rejection of misaligned or unlatched writes;
- both clock polarities;
- resuming a paused command.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_MEM  = 8'h03;
    localparam logic [7:0] OP_WR_MEM  = 8'h02;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_SR_DATA,
        ST_SR_READ,
        ST_DISCARD
    } cmd_state_e;

    typedef enum logic [1:0] {
        LOCK_NONE    = 2'b00,
        LOCK_QUARTER = 2'b01,
        LOCK_HALF    = 2'b10,
        LOCK_ALL     = 2'b11
    } lock_e;

    typedef enum logic [1:0] {
        JOB_NONE,
        JOB_PAGE,
        JOB_STATUS
    } job_e;

    typedef struct packed {
        logic [3:0] rsvd;
        lock_e      lock;
        logic       wel;
        logic       wip;
    } status_t;

    // top2 = the two most significant address bits
    function automatic logic addr_locked(input logic [1:0] top2, input lock_e code);
        case (code)
            LOCK_NONE:    addr_locked = 1'b0;
            LOCK_QUARTER: addr_locked = (top2 == 2'b11);
            LOCK_HALF:    addr_locked = top2[1];
            default:      addr_locked = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sbe_spi_port.sv
module sbe_spi_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_si,
    input  logic       hold_n,
    input  logic [7:0] tx_byte,
    output logic       spi_so,
    output logic       spi_so_oe,
    output logic       sel_start,
    output logic       sel_end,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       aligned
);
    logic       cs_n_q;
    logic       sck_q;
    logic [6:0] shift_q;
    logic [2:0] bit_idx;
    logic       sck_rise;

    assign sck_rise  = !spi_cs_n && hold_n && spi_sck && !sck_q;
    assign sel_start = cs_n_q && !spi_cs_n;
    assign sel_end   = !cs_n_q && spi_cs_n;
    assign byte_done = sck_rise && (bit_idx == 3'd7);
    assign rx_byte   = {shift_q, spi_si};
    assign aligned   = (bit_idx == 3'd0);
    assign spi_so    = tx_byte[3'd7 - bit_idx];
    assign spi_so_oe = !spi_cs_n && hold_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= 1'b1;
            sck_q   <= 1'b0;
            shift_q <= '0;
            bit_idx <= '0;
        end else begin
            cs_n_q <= spi_cs_n;
            sck_q  <= spi_sck;
            if (sel_start) begin
                bit_idx <= '0;
            end else if (sck_rise) begin
                shift_q <= {shift_q[5:0], spi_si};
                bit_idx <= bit_idx + 3'd1;
            end
        end
    end
endmodule

// File: rtl/sbe_mem_array.sv
module sbe_mem_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sbe_cmd_ctrl.sv
module sbe_cmd_ctrl
    import sbe_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              byte_done,
    input  logic              aligned,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output status_t           status
);
    localparam int PAGE_BYTES  = 1 << PAGE_W;
    localparam int BUSY_CYCLES = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
    localparam int CNT_W       = $clog2(BUSY_CYCLES + 1);
    localparam int HI_W        = ADDR_W - 8;
    localparam int BASE_W      = ADDR_W - PAGE_W;

    cmd_state_e              state;
    logic                    is_read;
    logic [HI_W-1:0]         addr_hi;
    logic [ADDR_W-1:0]       rd_addr;
    logic [BASE_W-1:0]       pg_base;
    logic [PAGE_W-1:0]       pg_off;
    logic [7:0]              buf_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]   buf_vld;
    logic                    sr_got;
    lock_e                   sr_lock;
    lock_e                   lock;
    logic                    wel;
    job_e                    job;
    logic [CNT_W-1:0]        cnt;
    logic [ADDR_W-1:0]       addr_full;
    logic [PAGE_W-1:0]       cidx;
    logic                    page_ok;
    logic                    sr_ok;

    assign addr_full = {addr_hi, rx_byte};
    assign cidx      = cnt[PAGE_W-1:0];

    assign page_ok = (state == ST_WR_DATA) && aligned && (|buf_vld) && wel &&
                     !addr_locked(pg_base[BASE_W-1 -: 2], lock);
    assign sr_ok   = (state == ST_SR_DATA) && sr_got && aligned && wel && wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OPCODE;
            is_read <= 1'b0;
            addr_hi <= '0;
            rd_addr <= '0;
            pg_base <= '0;
            pg_off  <= '0;
            buf_vld <= '0;
            sr_got  <= 1'b0;
            sr_lock <= LOCK_NONE;
            lock    <= LOCK_NONE;
            wel     <= 1'b0;
            job     <= JOB_NONE;
            cnt     <= '0;
        end else begin
            if (sel_start) begin
                state <= ST_OPCODE;
            end else if (byte_done) begin
                case (state)
                    ST_OPCODE: begin
                        if (job != JOB_NONE && rx_byte != OP_RD_STAT) begin
                            state <= ST_DISCARD;
                        end else begin
                            case (rx_byte)
                                OP_SET_WEL: begin wel <= 1'b1; state <= ST_DISCARD; end
                                OP_CLR_WEL: begin wel <= 1'b0; state <= ST_DISCARD; end
                                OP_RD_STAT: state <= ST_SR_READ;
                                OP_WR_STAT: begin sr_got <= 1'b0; state <= ST_SR_DATA; end
                                OP_RD_MEM:  begin is_read <= 1'b1; state <= ST_ADDR_HI; end
                                OP_WR_MEM:  begin is_read <= 1'b0; buf_vld <= '0; state <= ST_ADDR_HI; end
                                default:    state <= ST_DISCARD;
                            endcase
                        end
                    end
                    ST_ADDR_HI: begin
                        addr_hi <= rx_byte[HI_W-1:0];
                        state   <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        if (is_read) begin
                            rd_addr <= addr_full;
                            state   <= ST_RD_DATA;
                        end else begin
                            pg_base <= addr_full[ADDR_W-1:PAGE_W];
                            pg_off  <= addr_full[PAGE_W-1:0];
                            state   <= ST_WR_DATA;
                        end
                    end
                    ST_RD_DATA: rd_addr <= rd_addr + 1'b1;
                    ST_WR_DATA: begin
                        buf_vld[pg_off] <= 1'b1;
                        pg_off          <= pg_off + 1'b1;
                    end
                    ST_SR_DATA: begin
                        if (!sr_got) begin
                            sr_lock <= lock_e'(rx_byte[3:2]);
                            sr_got  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (sel_end && job == JOB_NONE) begin
                if (page_ok) begin
                    job <= JOB_PAGE;
                    cnt <= '0;
                end else if (sr_ok) begin
                    lock <= sr_lock;
                    job  <= JOB_STATUS;
                    cnt  <= '0;
                end
            end

            if (job != JOB_NONE) begin
                if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
                    job     <= JOB_NONE;
                    wel     <= 1'b0;
                    buf_vld <= '0;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!sel_start && byte_done && state == ST_WR_DATA) buf_data[pg_off] <= rx_byte;
    end

    assign mem_we    = (job == JOB_PAGE) && (cnt < CNT_W'(PAGE_BYTES)) && buf_vld[cidx];
    assign mem_waddr = {pg_base, cidx};
    assign mem_wdata = buf_data[cidx];
    assign mem_raddr = rd_addr;

    assign status = '{rsvd: 4'b0000, lock: lock, wel: wel, wip: (job != JOB_NONE)};

    always_comb begin
        case (state)
            ST_SR_READ: tx_byte = status;
            ST_RD_DATA: tx_byte = mem_rdata;
            default:    tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/sbe_eeprom.sv
module sbe_eeprom
    import sbe_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe,
    input  logic hold_n,
    input  logic wp_n
);
    logic              sel_start;
    logic              sel_end;
    logic              byte_done;
    logic              aligned;
    logic [7:0]        rx_byte;
    logic [7:0]        tx_byte;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    status_t           st;
    logic              st_wip;
    logic              st_wel;
    logic [1:0]        st_lock;

    assign st_wip  = st.wip;
    assign st_wel  = st.wel;
    assign st_lock = st.lock;

    sbe_spi_port u_port (
        .clk       (clk),
        .rst       (rst),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_si    (spi_si),
        .hold_n    (hold_n),
        .tx_byte   (tx_byte),
        .spi_so    (spi_so),
        .spi_so_oe (spi_so_oe),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .aligned   (aligned)
    );

    sbe_cmd_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wp_n      (wp_n),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .byte_done (byte_done),
        .aligned   (aligned),
        .rx_byte   (rx_byte),
        .mem_rdata (mem_rdata),
        .tx_byte   (tx_byte),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .status    (st)
    );

    sbe_mem_array #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/sbe_eeprom_chk.sv
module sbe_eeprom_chk
    import sbe_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_n,
    input logic              wp_n,
    input logic              byte_done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic              st_wip,
    input logic              st_wel,
    input logic [1:0]        st_lock
);
    p_locked_page_unwritten_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !addr_locked(mem_waddr[ADDR_W-1 -: 2], lock_e'(st_lock)));

    p_wp_freezes_lock_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_lock) |-> $past(wp_n));

    p_busy_start_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_wip) |-> $past(st_wel));

    p_wel_clear_on_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(st_wip) |-> !st_wel);

    p_busy_blocks_wel_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(st_wip) && st_wip) |-> !$rose(st_wel));

    p_hold_stalls_shift_r12: assert property (@(posedge clk) disable iff (rst)
        !hold_n |-> !byte_done);
endmodule

bind sbe_eeprom sbe_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold_n    (hold_n),
    .wp_n      (wp_n),
    .byte_done (byte_done),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .st_wip    (st_wip),
    .st_wel    (st_wel),
    .st_lock   (st_lock)
);

// File: tb/sbe_eeprom_bench.sv
module sbe_eeprom_bench;
    localparam int WRC = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic wp_n = 1'b1;
    logic so;
    logic so_oe;
    logic mode3 = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] got;

    always #10 clk = ~clk;

    sbe_eeprom #(.ADDR_W(12), .PAGE_W(5), .WR_CYCLES(WRC)) u_sbe_eeprom (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .hold_n(hold_n), .wp_n(wp_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] v, input int n, output logic [7:0] r);
        r = 8'h00;
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            si  = v[7-i];
            repeat (4) @(negedge clk);
            r   = {r[6:0], so};
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic spi_begin();
        sck = mode3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic spi_end();
        if (!mode3) sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v);
        logic [7:0] d;
        spi_bits(v, 8, d);
    endtask

    task automatic recv(output logic [7:0] r);
        spi_bits(8'h00, 8, r);
    endtask

    task automatic op1(input logic [7:0] op);
        spi_begin(); send(op); spi_end();
    endtask

    task automatic rdsr(output logic [7:0] s);
        spi_begin(); send(8'h05); recv(s); spi_end();
    endtask

    task automatic wr_stat(input logic [7:0] v);
        spi_begin(); send(8'h01); send(v); spi_end();
    endtask

    // writes n bytes d0, d0+1, ... starting at address a
    task automatic wr_mem(input logic [15:0] a, input int n, input logic [7:0] d0);
        spi_begin(); send(8'h02); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) send(d0 + 8'(i));
        spi_end();
    endtask

    task automatic rd_one(input logic [15:0] a, output logic [7:0] r);
        spi_begin(); send(8'h03); send(a[15:8]); send(a[7:0]); recv(r); spi_end();
    endtask

    task automatic wait_idle();
        repeat (WRC + 20) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] a, b;
        chk("R12 oe idle after reset", {7'd0, so_oe}, 8'h00);
        spi_begin(); send(8'h05); recv(a); recv(b); spi_end();
        chk("R3 status after reset", a, 8'h00);
        chk("R3 status repeats", b, 8'h00);
    endtask

    task automatic t_latch();
        op1(8'h06); rdsr(got); chk("R2 set latch", got, 8'h02);
        op1(8'h04); rdsr(got); chk("R2 clear latch", got, 8'h00);
        mode3 = 1'b1;
        op1(8'h06); rdsr(got); chk("R1 mode3 set latch", got, 8'h02);
        op1(8'h04); rdsr(got); chk("R1 mode3 clear latch", got, 8'h00);
        mode3 = 1'b0;
    endtask

    task automatic t_page_write();
        logic [7:0] r [4];
        op1(8'h06);
        wr_mem(16'hF123, 4, 8'hA0);
        rdsr(got); chk("R7 busy and latch after write", got, 8'h03);
        wait_idle();
        rdsr(got); chk("R7 idle and latch clear", got, 8'h00);
        spi_begin(); send(8'h03); send(8'h01); send(8'h23);
        for (int i = 0; i < 4; i++) recv(r[i]);
        spi_end();
        for (int i = 0; i < 4; i++) chk("R4 stream read", r[i], 8'hA0 + 8'(i));
        mode3 = 1'b1;
        rd_one(16'h0124, got); chk("R1 mode3 read", got, 8'hA1);
        mode3 = 1'b0;
    endtask

    task automatic t_page_wrap();
        op1(8'h06); wr_mem(16'h0023, 1, 8'h77); wait_idle();
        op1(8'h06); wr_mem(16'h003E, 5, 8'h51); wait_idle();
        rd_one(16'h003E, got); chk("R5 first byte", got, 8'h51);
        rd_one(16'h003F, got); chk("R5 page end byte", got, 8'h52);
        rd_one(16'h0020, got); chk("R5 wrapped to page start", got, 8'h53);
        rd_one(16'h0022, got); chk("R5 last wrapped byte", got, 8'h55);
        rd_one(16'h0023, got); chk("R5 unsent byte kept", got, 8'h77);
    endtask

    task automatic t_array_wrap();
        logic [7:0] a, b;
        op1(8'h06); wr_mem(16'h0FFF, 1, 8'hEE); wait_idle();
        op1(8'h06); wr_mem(16'h0000, 1, 8'hDD); wait_idle();
        spi_begin(); send(8'h03); send(8'h0F); send(8'hFF); recv(a); recv(b); spi_end();
        chk("R4 last address", a, 8'hEE);
        chk("R4 wrap to zero", b, 8'hDD);
    endtask

    task automatic t_reject();
        logic [7:0] d;
        wr_mem(16'h0123, 1, 8'h11);
        rdsr(got); chk("R6 no latch no busy", got, 8'h00);
        rd_one(16'h0123, got); chk("R6 no latch array kept", got, 8'hA0);
        op1(8'h06);
        spi_begin(); send(8'h02); send(8'h01); send(8'h24); send(8'h99);
        spi_bits(8'hFF, 3, d);
        spi_end();
        rdsr(got); chk("R6 misaligned no busy", got, 8'h02);
        rd_one(16'h0124, got); chk("R6 misaligned array kept", got, 8'hA1);
        op1(8'h04);
    endtask

    task automatic t_busy();
        op1(8'h06); wr_mem(16'h0125, 1, 8'h42);
        op1(8'h04);
        rdsr(got); chk("R8 clear ignored while busy", got, 8'h03);
        rd_one(16'h0124, got); chk("R8 read ignored while busy", got, 8'h00);
        wait_idle();
        rdsr(got); chk("R8 idle after busy", got, 8'h00);
        rd_one(16'h0125, got); chk("R8 busy write landed", got, 8'h42);
    endtask

    task automatic t_lock();
        op1(8'h06); wr_stat(8'h04);
        rdsr(got); chk("R9 status write busy", got, 8'h07);
        wait_idle();
        rdsr(got); chk("R9 quarter lock set", got, 8'h04);
        op1(8'h06); wr_mem(16'h0FFF, 1, 8'h12);
        rdsr(got); chk("R10 quarter reject keeps latch", got, 8'h06);
        rd_one(16'h0FFF, got); chk("R10 quarter protected byte", got, 8'hEE);
        wr_mem(16'h0800, 1, 8'h34);
        rdsr(got); chk("R10 below quarter accepted", got, 8'h07);
        wait_idle();
        op1(8'h06); wr_stat(8'h08); wait_idle();
        rdsr(got); chk("R9 half lock set", got, 8'h08);
        op1(8'h06); wr_mem(16'h0800, 1, 8'h56);
        rdsr(got); chk("R10 half reject", got, 8'h0A);
        rd_one(16'h0800, got); chk("R10 half protected byte", got, 8'h34);
        wr_stat(8'h0C); wait_idle();
        op1(8'h06); wr_mem(16'h0000, 1, 8'h99);
        rdsr(got); chk("R10 all reject", got, 8'h0E);
        rd_one(16'h0000, got); chk("R10 all protected byte", got, 8'hDD);
        wr_stat(8'h00); wait_idle();
        rdsr(got); chk("R9 unlock", got, 8'h00);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        op1(8'h06); wr_stat(8'h0C);
        rdsr(got); chk("R11 status write dropped", got, 8'h02);
        wp_n = 1'b1;
        op1(8'h04);
        rdsr(got); chk("R11 lock still clear", got, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        spi_begin(); send(8'h03); send(8'h01);
        hold_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 oe low in pause", {7'd0, so_oe}, 8'h00);
        spi_bits(8'hFF, 8, d);
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 oe back after pause", {7'd0, so_oe}, 8'h01);
        send(8'h23); recv(got); spi_end();
        chk("R12 command resumed", got, 8'hA0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_latch();
        t_page_write();
        t_page_wrap();
        t_array_wrap();
        t_reject();
        t_busy();
        t_lock();
        t_wp();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule